// File: doc/BRIEF.md
# Dual-mode dual-slope conversion sequencer

This block is the digital half of a dual-slope integrating converter that measures either a steady (DC) input or a synchronously rectified AC input. A free-running divider turns the fast system clock into a slow conversion tick. A two-bit Johnson sequencer then steps through four equal phases: clear, integrate, de-integrate and present. The sequence repeats without end. In every phase the block drives six analog switch enables.

In AC mode, a polarity comparator sampled on its own fast clock steers switch 5 during integration. The input is inverted whenever it lies below the common-mode level, so the integrator sees a rectified signal. In DC mode, the same polarity bit picks the sign of the reference during de-integration.

A tick counter measures how long de-integration lasts before the integrator comparator trips. The count is published as a result code with a one-cycle valid strobe on entry to the present phase. If the comparator never trips, the code saturates at full scale and an overflow flag is raised.

Top module: `dsadc_ctrl`

## Requirements
- R1: A tick occurs every DIV clk_i cycles. The phases run clear, integrate, de-integrate, present, then clear again, and each phase lasts PHASE_TICKS ticks.
- R2: In the clear phase, sw_o is 6'b110100 in both modes. Bit k-1 of sw_o drives switch k, so switches 3, 5 and 6 are on.
- R3: In the integrate phase, sw_o is 6'b011001 in DC mode (ac_mode_i=0). In AC mode, sw_o[3] and sw_o[0] are on, sw_o[4] equals the synchronized polarity bit (1 = input below common mode), and all other bits are off.
- R4: In the de-integrate and present phases, sw_o[3] and sw_o[1] are on and sw_o[5], sw_o[2] and sw_o[0] are off. sw_o[4] equals the synchronized polarity bit in DC mode and is 0 in AC mode.
- R5: pol_cmp_i passes through two flops clocked by pol_clk_i and then two flops clocked by clk_i. A level held steady for 6 clk_i cycles appears on sw_o[4] wherever that bit follows polarity.
- R6: The result is the index (0 to PHASE_TICKS-1) of the first de-integrate tick at which int_cmp_i is sampled high. In that case ovf_o is 0.
- R7: If int_cmp_i is never high on a de-integrate tick, result_o is all ones and ovf_o is 1.
- R8: int_cmp_i has no effect at ticks outside the de-integrate phase, or after the first trip within one de-integration.
- R9: valid_o is high for exactly one clk_i cycle, right after the tick that enters the present phase. result_o and ovf_o change only in that cycle.
- R10: While rst_ni is low: sw_o is 6'b110100, valid_o is 0, result_o is 0 and ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pol_clk_i | input | 1 | Fast clock for the polarity comparator |
| ac_mode_i | input | 1 | 1 selects AC (rectifying) mode, 0 selects DC mode |
| pol_cmp_i | input | 1 | Polarity comparator, 1 when the input is below common mode |
| int_cmp_i | input | 1 | Integrator comparator, 1 once the integrator crosses 0 V |
| sw_o | output | 6 | Switch enables, bit k-1 drives switch k |
| result_o | output | $clog2(PHASE_TICKS) | Conversion code |
| ovf_o | output | 1 | Saturated result, no trip seen |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
Two events can fall on the same tick: a comparator trip on the final de-integrate tick, and the phase advance that publishes the result. That tick must therefore capture its own trip rather than the saturated value. The case is provoked by directed conversions that trip at index PHASE_TICKS-1, and by random trip indices that sometimes land there. It is judged by expecting result PHASE_TICKS-1 with overflow clear, which is distinct from a conversion that never trips: there, the same code is expected with overflow set.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  // Johnson order: 00 -> 01 -> 11 -> 10
  typedef enum logic [1:0] {
    PH_CLR = 2'b00,
    PH_INT = 2'b01,
    PH_DEI = 2'b11,
    PH_OUT = 2'b10
  } phase_e;

  localparam int unsigned NUM_SW = 6;

  function automatic phase_e next_phase(input phase_e p);
    logic [1:0] q;
    q = p;
    return phase_e'({q[0], ~q[1]});
  endfunction
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_tick_div.sv
module dsadc_tick_div #(
  parameter int unsigned DIV = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsadc_phase_seq.sv
module dsadc_phase_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 128,
  localparam int unsigned CW = $clog2(PHASE_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;
  assign last_o  = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_CLR;
      cnt_q <= '0;
    end else if (last_o) begin
      ph_q  <= next_phase(ph_q);
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsadc_sw_dec.sv
module dsadc_sw_dec
  import dsadc_pkg::*;
(
  input  phase_e              phase_i,
  input  logic                ac_mode_i,
  input  logic                pol_i,
  output logic [NUM_SW-1:0]   sw_o
);
  // bit k-1 drives switch k
  always_comb begin
    sw_o = '0;
    unique case (phase_i)
      PH_CLR: begin
        sw_o[2] = 1'b1;
        sw_o[4] = 1'b1;
        sw_o[5] = 1'b1;
      end
      PH_INT: begin
        sw_o[0] = 1'b1;
        sw_o[3] = 1'b1;
        sw_o[4] = ac_mode_i ? pol_i : 1'b1;  // AC: invert while below common mode
      end
      PH_DEI, PH_OUT: begin
        sw_o[1] = 1'b1;
        sw_o[3] = 1'b1;
        sw_o[4] = ac_mode_i ? 1'b0 : pol_i;  // DC: reference sign
      end
      default: sw_o = '0;
    endcase
  end
endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture
  import dsadc_pkg::*;
#(
  parameter int unsigned RW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          last_i,
  input  phase_e        phase_i,
  input  logic [RW-1:0] cnt_i,
  input  logic          cmp_i,
  output logic [RW-1:0] result_o,
  output logic          ovf_o,
  output logic          valid_o
);
  logic          tripped_q;
  logic [RW-1:0] cap_q;
  logic          hit;
  logic          enter_dei;
  logic          enter_out;

  assign hit       = tick_i && (phase_i == PH_DEI) && cmp_i && !tripped_q;
  assign enter_dei = last_i && (phase_i == PH_INT);
  assign enter_out = last_i && (phase_i == PH_DEI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tripped_q <= 1'b0;
      cap_q     <= '0;
    end else if (enter_dei) begin
      tripped_q <= 1'b0;
    end else if (hit) begin
      tripped_q <= 1'b1;
      cap_q     <= cnt_i;
    end
  end

  // trip on the final de-integrate tick is folded in here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= enter_out;
      if (enter_out) begin
        if (hit) begin
          result_o <= cnt_i;
          ovf_o    <= 1'b0;
        end else if (tripped_q) begin
          result_o <= cap_q;
          ovf_o    <= 1'b0;
        end else begin
          result_o <= '1;
          ovf_o    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned DIV         = 1560,
  parameter int unsigned PHASE_TICKS = 128,
  parameter int unsigned SYNC_FAST   = 2,
  parameter int unsigned SYNC_SYS    = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           pol_clk_i,
  input  logic                           ac_mode_i,
  input  logic                           pol_cmp_i,
  input  logic                           int_cmp_i,
  output logic [5:0]                     sw_o,
  output logic [$clog2(PHASE_TICKS)-1:0] result_o,
  output logic                           ovf_o,
  output logic                           valid_o
);
  localparam int unsigned RW = $clog2(PHASE_TICKS);

  logic          tick;
  logic          last;
  phase_e        phase;
  logic [RW-1:0] ph_cnt;
  logic          pol_fast;
  logic          pol_sys;

  dsadc_tick_div #(.DIV(DIV)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  dsadc_phase_seq #(.PHASE_TICKS(PHASE_TICKS)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .phase_o (phase),
    .cnt_o   (ph_cnt),
    .last_o  (last)
  );

  dsadc_sync #(.STAGES(SYNC_FAST)) i_pol_fast (
    .clk_i  (pol_clk_i),
    .rst_ni (rst_ni),
    .d_i    (pol_cmp_i),
    .q_o    (pol_fast)
  );

  dsadc_sync #(.STAGES(SYNC_SYS)) i_pol_sys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pol_fast),
    .q_o    (pol_sys)
  );

  dsadc_sw_dec i_dec (
    .phase_i   (phase),
    .ac_mode_i (ac_mode_i),
    .pol_i     (pol_sys),
    .sw_o      (sw_o)
  );

  dsadc_capture #(.RW(RW)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .last_i   (last),
    .phase_i  (phase),
    .cnt_i    (ph_cnt),
    .cmp_i    (int_cmp_i),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk
  import dsadc_pkg::*;
#(
  parameter int unsigned RW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input phase_e        phase_i,
  input logic [5:0]    sw_o,
  input logic [RW-1:0] result_o,
  input logic          ovf_o,
  input logic          valid_o
);
  // R1
  a_r1_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != $past(phase_i)) |-> (phase_i == next_phase($past(phase_i))));

  // R2
  a_r2_clear_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_CLR) |-> (sw_o == 6'b110100));

  // R4
  a_r4_dei_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_DEI || phase_i == PH_OUT) |->
      (sw_o[1] && sw_o[3] && !sw_o[0] && !sw_o[2] && !sw_o[5]));

  // R7
  a_r7_ovf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o == {RW{1'b1}}));

  // R9
  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_valid_at_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (phase_i == PH_OUT && $past(phase_i) == PH_DEI));

  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(ovf_o)));
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.RW($clog2(PHASE_TICKS))) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .phase_i  (phase),
  .sw_o     (sw_o),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .valid_o  (valid_o)
);

// File: tb/test_dsadc_ctrl.sv
`timescale 1ns/1ps
module test_dsadc_ctrl;
  localparam int DIV   = 4;
  localparam int P     = 16;
  localparam int RW    = 4;
  localparam int FULL  = 15;
  localparam int NCONV = 24;

  logic clk = 1'b0, pol_clk = 1'b0, rst_n = 1'b0;
  logic ac_mode = 1'b0, pol_cmp = 1'b0, int_cmp = 1'b0;
  logic [5:0]    sw;
  logic [RW-1:0] result;
  logic          ovf, valid;

  int  checks = 0, fails = 0;
  bit  done = 0;
  int  trip_t [NCONV];
  bit  hold   [NCONV];
  bit  noise  [NCONV];
  bit  mode   [NCONV];

  always #2.5 clk = ~clk;
  always #1.5 pol_clk = ~pol_clk;

  dsadc_ctrl #(.DIV(DIV), .PHASE_TICKS(P)) i_dsadc_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pol_clk_i (pol_clk),
    .ac_mode_i (ac_mode),
    .pol_cmp_i (pol_cmp),
    .int_cmp_i (int_cmp),
    .sw_o      (sw),
    .result_o  (result),
    .ovf_o     (ovf),
    .valid_o   (valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // phase index: 0 clear, 1 integrate, 2 de-integrate, 3 present
  function automatic logic [5:0] exp_sw(input int ph, input bit ac, input bit pol);
    case (ph)
      0:       return 6'b110100;
      1:       return ac ? {1'b0, pol, 4'b1001} : 6'b011001;
      default: return {1'b0, ac ? 1'b0 : pol, 4'b1010};
    endcase
  endfunction

  function automatic bit pol_used(input int ph, input bit ac);
    return (ph == 1 && ac) || (ph >= 2 && !ac);
  endfunction

  initial begin
    int ncyc, ticks, ph, pc, cv, pol_age, t;
    logic [5:0] e, m;
    logic [RW-1:0] last_res;
    bit last_ovf, exp_v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NCONV; i++) begin
      trip_t[i] = $urandom % (P + 2);
      hold[i]   = $urandom % 2;
      noise[i]  = $urandom % 2;
      mode[i]   = $urandom % 2;
    end
    trip_t[0] = 0;     hold[0] = 1; noise[0] = 1; mode[0] = 0;
    trip_t[1] = P - 1; hold[1] = 1; noise[1] = 0; mode[1] = 1;
    trip_t[2] = P;     hold[2] = 0; noise[2] = 1; mode[2] = 0;
    trip_t[3] = 5;     hold[3] = 0; noise[3] = 1; mode[3] = 1;
    trip_t[4] = P - 1; hold[4] = 0; noise[4] = 1; mode[4] = 0;

    ac_mode = mode[0];
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sw == 6'b110100, "R10 sw in reset", sw, 6'b110100);
    chk(valid == 1'b0, "R10 valid in reset", valid, 0);
    chk(result == '0, "R10 result in reset", result, 0);
    chk(ovf == 1'b0, "R10 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    ncyc = 0; pol_age = 0; last_res = '0; last_ovf = 0;

    while (1) begin
      @(negedge clk);
      ncyc++;
      ticks = ncyc / DIV;
      cv = ticks / (4 * P);
      if (cv >= NCONV) break;
      ph = (ticks / P) % 4;
      pc = ticks % P;
      pol_age++;

      // R1..R5 switch pattern
      e = exp_sw(ph, ac_mode, pol_cmp);
      m = (pol_used(ph, ac_mode) && pol_age < 6) ? 6'b101111 : 6'b111111;
      if (ph == 0)      chk((sw & m) == (e & m), "R2 clear switches", sw, e);
      else if (ph == 1) chk((sw & m) == (e & m), "R3 integrate switches (R1 R5)", sw, e);
      else              chk((sw & m) == (e & m), "R4 de-integrate switches (R1 R5)", sw, e);

      // R9 strobe timing and result
      exp_v = (ncyc % DIV == 0) && (ticks % (4 * P) == 3 * P);
      chk(valid == exp_v, "R9 valid strobe", valid, exp_v);
      if (exp_v) begin
        t = trip_t[cv];
        if (t < P) begin
          chk(result == RW'(t), "R6 trip count (R8)", result, t);
          chk(ovf == 1'b0, "R6 no overflow", ovf, 0);
        end else begin
          chk(result == RW'(FULL), "R7 saturated code", result, FULL);
          chk(ovf == 1'b1, "R7 overflow flag", ovf, 1);
        end
        last_res = result; last_ovf = ovf;
      end else begin
        chk(result == last_res && ovf == last_ovf, "R9 result held", result, last_res);
      end

      // drive for the next edge
      if (ph == 0) ac_mode = mode[cv];
      if (ph == 2) int_cmp = hold[cv] ? (pc >= trip_t[cv]) : (pc == trip_t[cv]);
      else         int_cmp = noise[cv] ? 1'($urandom % 2) : 1'b0;
      if ($urandom % 40 == 0) begin
        pol_cmp = ~pol_cmp;
        pol_age = 0;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end
endmodule